// File: doc/BRIEF.md
# Serial Test-Vector Access Wrapper

This block places a small combinational device under test inside the logic fabric. A host with only a few I/O pins can then exercise a device that has more inputs than the host has pins. The host supplies its own shift clock and sends a stimulus word bit by bit on one data pin. When the word is complete, the host strobes it into a holding register that drives the device inputs. It then strobes the device outputs into a response register and clocks the response back out on one data pin.

All state is clocked by the host's shift clock; there is no local clock. The holding register decouples the device from the shift register, so the device never sees a partly shifted word. Reading a response and shifting in the next stimulus can overlap, because one shift strobe moves both registers. The built-in device is a six-gate NAND network with five inputs and two outputs. Other widths get a generic NAND network.

Top module: `serial_vector_wrapper`

## Requirements
- R1: A high `rst` at a `tck` edge clears the stimulus shift register, the holding register and the response register to zero, so `sdo` reads 0 and a capture with no new apply returns the response of the all-zero word.
- R2: With `shift_en` high, each `tck` edge moves the stimulus register one place toward bit 0 and loads `sdi` into its top bit. After `IN_W` shifts, the first bit sent is device input bit 0 (LSB first).
- R3: With `shift_en` low, the stimulus register keeps its contents and `sdi` is ignored.
- R4: The device inputs change only at an edge with `apply_en` high. Shifting without an apply leaves the applied word, and so the captured response, unchanged.
- R5: An edge with `capture_en` high loads the device outputs into the response register, and response bit 0 appears on `sdo` right after that edge.
- R6: With `shift_en` high and `capture_en` low, the response register shifts toward bit 0 and fills with 0. Bits leave LSB first, and after `OUT_W` shifts `sdo` is 0.
- R7: When `capture_en` and `shift_en` are both high, the capture wins on the response register.
- R8: For the default widths, with inputs i0..i4 as bits 0..4, p=NAND(i0,i2), q=NAND(i2,i3), r=NAND(i1,q) and s=NAND(q,i4). Output bit 0 is NAND(p,r) and output bit 1 is NAND(r,s).
- R9: An apply at the same edge as a shift loads the stimulus word as it stood before that shift.
- R10: A capture at the same edge as an apply samples the response to the previously applied word. The new word's response is seen by a capture one or more edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Host-supplied shift clock, the only clock |
| rst | input | 1 | Synchronous active-high reset |
| sdi | input | 1 | Serial stimulus data from the host |
| shift_en | input | 1 | Shift both serial registers on this edge |
| apply_en | input | 1 | Copy the stimulus word to the device inputs |
| capture_en | input | 1 | Load the device outputs into the response register |
| sdo | output | 1 | Serial response data to the host (response bit 0) |

## Verification
The bench builds the wrapper with its default widths, five inputs and two outputs, which selects the six-NAND device. At these widths all 32 stimulus words can be sent around the full shift-apply-capture-read loop and checked against equations written in the bench. The small widths also make the strobe collisions easy to set up: apply during shift, capture during shift, capture with apply, and a reset in the middle of a run. In each collision case the losing outcome gives a response that differs from the expected one.

// File: rtl/swv_pkg.sv
package swv_pkg;

    typedef enum logic [1:0] {
        RSP_KEEP  = 2'd0,
        RSP_SHIFT = 2'd1,
        RSP_LOAD  = 2'd2
    } rsp_op_e;

    typedef struct packed {
        logic    stim_shift;
        logic    hold_load;
        rsp_op_e rsp_op;
    } swv_ctrl_t;

    function automatic swv_ctrl_t decode_ctrl(input logic shift_en,
                                              input logic apply_en,
                                              input logic capture_en);
        swv_ctrl_t c;
        c.stim_shift = shift_en;
        c.hold_load  = apply_en;
        if (capture_en)    c.rsp_op = RSP_LOAD;
        else if (shift_en) c.rsp_op = RSP_SHIFT;
        else               c.rsp_op = RSP_KEEP;
        return c;
    endfunction

    function automatic logic nand2(input logic a, input logic b);
        return ~(a & b);
    endfunction

endpackage

// File: rtl/swv_stim_shift.sv
module swv_stim_shift #(
    parameter int IN_W = 5
) (
    input  logic            tck,
    input  logic            rst,
    input  logic            shift,
    input  logic            sdi,
    output logic [IN_W-1:0] word
);
    logic [IN_W-1:0] sr_q;

    always_ff @(posedge tck) begin
        if (rst)        sr_q <= '0;
        else if (shift) begin
            if (IN_W > 1) sr_q <= {sdi, sr_q[IN_W-1:1]};
            else          sr_q <= sdi;
        end
    end

    assign word = sr_q;
endmodule

// File: rtl/swv_hold_reg.sv
module swv_hold_reg #(
    parameter int IN_W = 5
) (
    input  logic            tck,
    input  logic            rst,
    input  logic            load,
    input  logic [IN_W-1:0] d,
    output logic [IN_W-1:0] q
);
    logic [IN_W-1:0] q_r;

    always_ff @(posedge tck) begin
        if (rst)       q_r <= '0;
        else if (load) q_r <= d;
    end

    assign q = q_r;
endmodule

// File: rtl/swv_nand_dev.sv
module swv_nand_dev
    import swv_pkg::*;
#(
    parameter int IN_W  = 5,
    parameter int OUT_W = 2
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);
    generate
        if (IN_W == 5 && OUT_W == 2) begin : g_six_nand
            logic p, q, r, s;
            assign p       = nand2(din[0], din[2]);
            assign q       = nand2(din[2], din[3]);
            assign r       = nand2(din[1], q);
            assign s       = nand2(q, din[4]);
            assign dout[0] = nand2(p, r);
            assign dout[1] = nand2(r, s);
        end else begin : g_generic
            for (genvar j = 0; j < OUT_W; j++) begin : g_out
                localparam int IA = j % IN_W;
                localparam int IB = (j + 1) % IN_W;
                assign dout[j] = nand2(din[IA], din[IB]);
            end
        end
    endgenerate
endmodule

// File: rtl/swv_resp_shift.sv
module swv_resp_shift
    import swv_pkg::*;
#(
    parameter int OUT_W = 2
) (
    input  logic             tck,
    input  logic             rst,
    input  rsp_op_e          op,
    input  logic [OUT_W-1:0] cap,
    output logic [OUT_W-1:0] word,
    output logic             sout
);
    logic [OUT_W-1:0] sr_q;

    always_ff @(posedge tck) begin
        if (rst) sr_q <= '0;
        else begin
            case (op)
                RSP_LOAD:  sr_q <= cap;
                RSP_SHIFT: sr_q <= sr_q >> 1;
                default:   sr_q <= sr_q;
            endcase
        end
    end

    assign word = sr_q;
    assign sout = sr_q[0];
endmodule

// File: rtl/serial_vector_wrapper.sv
module serial_vector_wrapper
    import swv_pkg::*;
#(
    parameter int IN_W  = 5,
    parameter int OUT_W = 2
) (
    input  logic tck,
    input  logic rst,
    input  logic sdi,
    input  logic shift_en,
    input  logic apply_en,
    input  logic capture_en,
    output logic sdo
);
    swv_ctrl_t        ctrl;
    logic [IN_W-1:0]  stim_word;
    logic [IN_W-1:0]  dev_in;
    logic [OUT_W-1:0] dev_out;
    logic [OUT_W-1:0] resp_word;

    assign ctrl = decode_ctrl(shift_en, apply_en, capture_en);

    swv_stim_shift #(.IN_W(IN_W)) u_stim (
        .tck(tck), .rst(rst), .shift(ctrl.stim_shift), .sdi(sdi), .word(stim_word)
    );

    swv_hold_reg #(.IN_W(IN_W)) u_hold (
        .tck(tck), .rst(rst), .load(ctrl.hold_load), .d(stim_word), .q(dev_in)
    );

    swv_nand_dev #(.IN_W(IN_W), .OUT_W(OUT_W)) u_dev (
        .din(dev_in), .dout(dev_out)
    );

    swv_resp_shift #(.OUT_W(OUT_W)) u_resp (
        .tck(tck), .rst(rst), .op(ctrl.rsp_op), .cap(dev_out),
        .word(resp_word), .sout(sdo)
    );
endmodule

// File: rtl/swv_checker.sv
module swv_checker #(
    parameter int IN_W  = 5,
    parameter int OUT_W = 2
) (
    input logic             tck,
    input logic             rst,
    input logic             sdi,
    input logic             shift_en,
    input logic             apply_en,
    input logic             capture_en,
    input logic [IN_W-1:0]  stim_word,
    input logic [IN_W-1:0]  dev_in,
    input logic [OUT_W-1:0] dev_out,
    input logic [OUT_W-1:0] resp_word
);
    AST_RESET_CLEARS: assert property (@(posedge tck)
        rst |=> (stim_word == '0 && dev_in == '0 && resp_word == '0)); // R1

    AST_SHIFT_IN_TOP: assert property (@(posedge tck) disable iff (rst)
        shift_en |=> stim_word[IN_W-1] == $past(sdi)); // R2

    AST_STIM_IDLE: assert property (@(posedge tck) disable iff (rst)
        !shift_en |=> $stable(stim_word)); // R3

    AST_HOLD_STABLE: assert property (@(posedge tck) disable iff (rst)
        !apply_en |=> $stable(dev_in)); // R4

    AST_APPLY_PRESHIFT: assert property (@(posedge tck) disable iff (rst)
        apply_en |=> dev_in == $past(stim_word)); // R9

    AST_CAPTURE_LOAD: assert property (@(posedge tck) disable iff (rst)
        capture_en |=> resp_word == $past(dev_out)); // R7

    AST_RESP_SHIFT: assert property (@(posedge tck) disable iff (rst)
        (shift_en && !capture_en) |=> resp_word == ($past(resp_word) >> 1)); // R6
endmodule

bind serial_vector_wrapper swv_checker #(.IN_W(IN_W), .OUT_W(OUT_W)) u_swv_checker (
    .tck(tck), .rst(rst), .sdi(sdi), .shift_en(shift_en), .apply_en(apply_en),
    .capture_en(capture_en), .stim_word(stim_word), .dev_in(dev_in),
    .dev_out(dev_out), .resp_word(resp_word)
);

// File: tb/serial_vector_wrapper_bench.sv
module serial_vector_wrapper_bench;
    localparam int IN_W  = 5;
    localparam int OUT_W = 2;

    logic tck = 1'b0;
    logic rst = 1'b1;
    logic sdi = 1'b0;
    logic shift_en = 1'b0;
    logic apply_en = 1'b0;
    logic capture_en = 1'b0;
    logic sdo;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 tck = ~tck;

    serial_vector_wrapper #(.IN_W(IN_W), .OUT_W(OUT_W)) u_serial_vector_wrapper (
        .tck(tck), .rst(rst), .sdi(sdi), .shift_en(shift_en),
        .apply_en(apply_en), .capture_en(capture_en), .sdo(sdo)
    );

    function automatic logic [OUT_W-1:0] expect_resp(input logic [IN_W-1:0] v);
        logic p, q, r, s;
        p = !(v[0] && v[2]);
        q = !(v[2] && v[3]);
        r = !(v[1] && q);
        s = !(q && v[4]);
        return {!(r && s), !(p && r)};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge tck);
        @(negedge tck);
    endtask

    task automatic shift_word(input logic [IN_W-1:0] v);
        for (int i = 0; i < IN_W; i++) begin
            sdi = v[i];
            shift_en = 1'b1;
            step();
        end
        shift_en = 1'b0;
        sdi = 1'b0;
    endtask

    task automatic pulse_apply();
        apply_en = 1'b1; step(); apply_en = 1'b0;
    endtask

    task automatic pulse_capture();
        capture_en = 1'b1; step(); capture_en = 1'b0;
    endtask

    task automatic read_resp(output logic [OUT_W-1:0] r);
        for (int i = 0; i < OUT_W; i++) begin
            r[i] = sdo;
            shift_en = 1'b1;
            step();
        end
        shift_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [OUT_W-1:0] r;
        rst = 1'b1; step(); step(); rst = 1'b0;
        check("R1 sdo after reset", sdo, 0);
        pulse_capture();
        read_resp(r);
        check("R1 response of cleared word", r, expect_resp('0));
        check("R1 response of cleared word is 0", r, 0);
    endtask

    task automatic t_all_words();
        logic [OUT_W-1:0] r;
        for (int v = 0; v < (1 << IN_W); v++) begin
            shift_word(v[IN_W-1:0]);
            pulse_apply();
            pulse_capture();
            read_resp(r);
            check("R8 R2 R5 full loop", r, expect_resp(v[IN_W-1:0]));
        end
    endtask

    task automatic t_idle_ignores_sdi();
        logic [OUT_W-1:0] r;
        shift_word(5'b10010);
        for (int i = 0; i < IN_W; i++) begin
            sdi = i[0];
            step();
        end
        sdi = 1'b0;
        pulse_apply();
        pulse_capture();
        read_resp(r);
        check("R3 idle shift keeps word", r, expect_resp(5'b10010));
    endtask

    task automatic t_no_partial();
        logic [OUT_W-1:0] r;
        shift_word(5'b00101);
        pulse_apply();
        for (int i = 0; i < 3; i++) begin
            sdi = 1'b1; shift_en = 1'b1; step();
        end
        shift_en = 1'b0; sdi = 1'b0;
        pulse_capture();
        read_resp(r);
        check("R4 applied word unchanged by shifting", r, expect_resp(5'b00101));
    endtask

    task automatic t_zero_fill_and_priority();
        logic [OUT_W-1:0] r;
        shift_word(5'b10010);
        pulse_apply();
        capture_en = 1'b1; shift_en = 1'b1; step();
        capture_en = 1'b0; shift_en = 1'b0;
        check("R7 capture wins over shift", sdo, expect_resp(5'b10010) & 1);
        check("R5 bit0 on sdo after capture", sdo, 1);
        read_resp(r);
        check("R6 LSB-first readout", r, expect_resp(5'b10010));
        check("R6 zero fill after readout", sdo, 0);
        shift_en = 1'b1; step(); shift_en = 1'b0;
        check("R6 zero fill stays", sdo, 0);
    endtask

    task automatic t_apply_during_shift();
        logic [OUT_W-1:0] r;
        shift_word(5'b00101);
        sdi = 1'b1; shift_en = 1'b1; apply_en = 1'b1; step();
        sdi = 1'b0; shift_en = 1'b0; apply_en = 1'b0;
        pulse_capture();
        read_resp(r);
        check("R9 apply takes pre-shift word", r, expect_resp(5'b00101));
    endtask

    task automatic t_capture_with_apply();
        logic [OUT_W-1:0] r;
        shift_word(5'b00101);
        pulse_apply();
        shift_word(5'b10010);
        apply_en = 1'b1; capture_en = 1'b1; step();
        apply_en = 1'b0; capture_en = 1'b0;
        read_resp(r);
        check("R10 capture sees earlier word", r, expect_resp(5'b00101));
        pulse_capture();
        read_resp(r);
        check("R10 later capture sees new word", r, expect_resp(5'b10010));
    endtask

    task automatic t_reset_midrun();
        logic [OUT_W-1:0] r;
        shift_word(5'b10010);
        pulse_apply();
        pulse_capture();
        rst = 1'b1; step(); rst = 1'b0;
        check("R1 sdo cleared mid-run", sdo, 0);
        pulse_apply();
        pulse_capture();
        read_resp(r);
        check("R1 stimulus register cleared", r, expect_resp('0));
    endtask

    initial begin
        step();
        t_reset();
        t_all_words();
        t_idle_ignores_sdi();
        t_no_partial();
        t_zero_fill_and_priority();
        t_apply_during_shift();
        t_capture_with_apply();
        t_reset_midrun();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge tck);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule